// File: doc/BRIEF.md
# Configurable Two-Port Block RAM

A parameterized on-chip memory with two independent ports, A and B, sharing one clock. Each port has an address, write data, a write strobe, per-lane byte enables, a read strobe and a read-data output. A parameter picks the operating style. Single-port uses port A only. Simple dual-port makes A write-only and B read-only. True dual-port lets both ports read and write. Read-only mode ignores every write. The array starts at all zeros.

Per-port parameters set several options. The read data can leave through a second output register or come straight from the read stage. Each port's input stage and output stage can honour its clock enable or ignore it. An asynchronous clear can empty the output stage, and for port A also the address stage. Separate parameters set what a port returns when it reads the word it is writing, and what it returns when the other port writes that word in the same cycle. With force-to-zero on, an output with no read behind it shows zero. Illegal parameter sets stop elaboration.

The ports carry no valid/ready handshake. The array accepts a request on every enabled clock and never applies back-pressure. A read strobe sampled by an enabled input stage marks a read in progress, and that mark follows the data down the pipeline.

Top module: `cfg_dpram`

## Requirements
- R1: In true dual-port mode both ports write. Only the lanes whose byte-enable bit is 1 change. Lane i covers data bits [i*BYTE_W +: BYTE_W]. If both ports write one word in the same cycle, port A's lanes win.
- R2: With the defaults, port A (output register off) shows read data one clock after the edge that samples the address. Port B (output register on) shows it two clocks after that edge.
- R3: Port A uses the keep-old-lanes setting. When it reads the address it writes, it returns the new data in enabled lanes and the stored data in the other lanes.
- R4: Port B uses the old-data setting. When it reads the address it writes, it returns the whole word as stored before the write.
- R5: The cross-port setting is new-data. A port that reads a word the other port writes in the same cycle sees the written lanes' new data and the stored data in the other lanes.
- R6: With force-to-zero on, a port's output is all zeros when no read is in progress at its output stage.
- R7: While a port's input clock enable is low, that port neither writes nor captures a read. Its read data holds its previous value.
- R8: While port B's output clock enable is low, its registered output holds its value.
- R9: Asserting the asynchronous clear zeroes port A's read output and port B's registered output at once, without waiting for a clock. The clear also sets both to "no read in progress".
- R10: In read-only mode, writes have no effect on the array. Reads of any address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| aclr | input | 1 | Asynchronous clear, active high |
| a_ce_in | input | 1 | Port A input-stage clock enable |
| a_ce_out | input | 1 | Port A output-register clock enable |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_be | input | DATA_W/BYTE_W | Port A lane enables |
| a_we | input | 1 | Port A write strobe |
| a_re | input | 1 | Port A read strobe |
| a_rdata | output | DATA_W | Port A read data |
| b_ce_in | input | 1 | Port B input-stage clock enable |
| b_ce_out | input | 1 | Port B output-register clock enable |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_be | input | DATA_W/BYTE_W | Port B lane enables |
| b_we | input | 1 | Port B write strobe |
| b_re | input | 1 | Port B read strobe |
| b_rdata | output | DATA_W | Port B read data |

## Verification
The read-stage properties assume the two ports never write the same word in one cycle. Under that assumption, a port's write of its own address cannot collide with a cross-port hit. The random stimulus drops port B's write strobe whenever it would target port A's write address. The properties are suspended while the clear is high. The bench raises the clear only on purpose and holds it across at least one edge, so the pipeline restarts from a known empty state.

// File: rtl/cfg_dpram_pkg.sv
package cfg_dpram_pkg;
  typedef enum int {
    MODE_SINGLE      = 0,
    MODE_SIMPLE_DUAL = 1,
    MODE_TRUE_DUAL   = 2,
    MODE_ROM         = 3
  } ram_mode_e;

  // own-port read of the word being written
  typedef enum int {
    RDW_NEW_MASKED = 0,  // unwritten lanes undefined
    RDW_NEW_KEEP   = 1,  // unwritten lanes keep stored data
    RDW_OLD        = 2   // whole word as before the write
  } rdw_same_e;

  // read of a word the other port writes in the same cycle
  typedef enum int {
    MIX_DONT_CARE = 0,
    MIX_NEW       = 1,
    MIX_OLD       = 2
  } rdw_mix_e;

  function automatic bit port_writes(ram_mode_e m, bit is_b);
    if (m == MODE_ROM) return 1'b0;
    if (is_b) return m == MODE_TRUE_DUAL;
    return 1'b1;
  endfunction

  function automatic bit port_reads(ram_mode_e m, bit is_b);
    if (is_b) return (m == MODE_SIMPLE_DUAL) || (m == MODE_TRUE_DUAL);
    return m != MODE_SIMPLE_DUAL;
  endfunction
endpackage

// File: rtl/dpram_store.sv
module dpram_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int BE_W   = 2,
  localparam int LANE_W = DATA_W / BE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [BE_W-1:0]   a_be,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [BE_W-1:0]   b_be,
  output logic [DATA_W-1:0] a_old,
  output logic [DATA_W-1:0] b_old
);
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // B lanes first, so A wins on a same-word collision
  always_ff @(posedge clk) begin
    for (int l = 0; l < BE_W; l++) begin
      if (b_wr && b_be[l]) mem[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
      if (a_wr && a_be[l]) mem[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
    end
  end

  assign a_old = mem[a_addr];
  assign b_old = mem[b_addr];
endmodule

// File: rtl/dpram_rd_port.sv
module dpram_rd_port import cfg_dpram_pkg::*; #(
  parameter int        DATA_W     = 16,
  parameter int        BE_W       = 2,
  parameter bit        CAN_READ   = 1'b1,
  parameter bit        OUT_REG    = 1'b0,
  parameter bit        ACLR_OUT   = 1'b1,
  parameter bit        ACLR_ADDR  = 1'b0,
  parameter bit        CE_IN_BYP  = 1'b0,
  parameter bit        CE_OUT_BYP = 1'b0,
  parameter rdw_same_e SAME       = RDW_NEW_KEEP,
  parameter rdw_mix_e  MIX        = MIX_OLD,
  parameter bit        FZ         = 1'b0,
  localparam int LANE_W = DATA_W / BE_W
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              ce_in,
  input  logic              ce_out,
  input  logic              re,
  input  logic              we,       // effective own write this cycle
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  input  logic [DATA_W-1:0] old_word,
  input  logic              x_hit,    // other port writes this word
  input  logic [DATA_W-1:0] x_wdata,
  input  logic [BE_W-1:0]   x_be,
  output logic [DATA_W-1:0] rdata
);
  logic              cap, ce_o, rd_req, clr1, clr2;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] word_q = '0;
  logic              vld_q  = 1'b0;
  logic [DATA_W-1:0] out_w;
  logic              ovld;

  assign cap    = CE_IN_BYP  || ce_in;
  assign ce_o   = CE_OUT_BYP || ce_out;
  assign rd_req = cap && re && CAN_READ;
  assign clr1   = aclr && (ACLR_ADDR || (ACLR_OUT && !OUT_REG));
  assign clr2   = aclr && ACLR_OUT && OUT_REG;

  always_comb begin
    merged = old_word;
    for (int l = 0; l < BE_W; l++) begin
      if (we && be[l]) begin
        if (SAME != RDW_OLD) merged[l*LANE_W +: LANE_W] = wdata[l*LANE_W +: LANE_W];
      end else if (x_hit && x_be[l] && MIX == MIX_NEW) begin
        merged[l*LANE_W +: LANE_W] = x_wdata[l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or posedge clr1) begin
    if (clr1) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else if (cap) begin
      vld_q <= rd_req;
      if (rd_req) word_q <= merged;
    end
  end

  a_r7_no_capture: assert property (@(posedge clk) disable iff (aclr)
    !cap |=> ($stable(word_q) && $stable(vld_q)));
  a_r4_old_word: assert property (@(posedge clk) disable iff (aclr)
    (rd_req && we && SAME == RDW_OLD) |=> word_q == $past(old_word));
  a_r3_full_write: assert property (@(posedge clk) disable iff (aclr)
    (rd_req && we && be == '1 && SAME != RDW_OLD) |=> word_q == $past(wdata));
  a_r5_mixed_new: assert property (@(posedge clk) disable iff (aclr)
    (rd_req && !we && x_hit && x_be == '1 && MIX == MIX_NEW) |=> word_q == $past(x_wdata));

  generate
    if (OUT_REG) begin : g_oreg
      logic [DATA_W-1:0] out_q = '0;
      logic              ovld_q = 1'b0;
      always_ff @(posedge clk or posedge clr2) begin
        if (clr2) begin
          out_q  <= '0;
          ovld_q <= 1'b0;
        end else if (ce_o) begin
          out_q  <= word_q;
          ovld_q <= vld_q;
        end
      end
      assign out_w = out_q;
      assign ovld  = ovld_q;
      a_r8_out_hold: assert property (@(posedge clk) disable iff (aclr)
        !ce_o |=> ($stable(out_q) && $stable(ovld_q)));
    end else begin : g_direct
      logic unused_ce;
      assign unused_ce = ce_o ^ clr2;
      assign out_w = word_q;
      assign ovld  = vld_q;
      if (FZ) begin : g_fz_chk
        a_r6_idle_zero: assert property (@(posedge clk) disable iff (aclr)
          (cap && !re) |=> rdata == '0);
      end
    end
  endgenerate

  assign rdata = (FZ && !ovld) ? '0 : out_w;
endmodule

// File: rtl/cfg_dpram.sv
module cfg_dpram import cfg_dpram_pkg::*; #(
  parameter ram_mode_e MODE        = MODE_TRUE_DUAL,
  parameter int        DATA_W      = 16,
  parameter int        ADDR_W      = 4,
  parameter int        BYTE_W      = 8,
  parameter bit        OUT_REG_A   = 1'b0,
  parameter bit        OUT_REG_B   = 1'b1,
  parameter bit        ACLR_OUT_A  = 1'b1,
  parameter bit        ACLR_OUT_B  = 1'b1,
  parameter bit        ACLR_ADDR_A = 1'b1,
  parameter bit        CE_IN_BYP_A = 1'b0,
  parameter bit        CE_IN_BYP_B = 1'b0,
  parameter bit        CE_OUT_BYP_A = 1'b0,
  parameter bit        CE_OUT_BYP_B = 1'b0,
  parameter rdw_same_e RDW_A       = RDW_NEW_KEEP,
  parameter rdw_same_e RDW_B       = RDW_OLD,
  parameter rdw_mix_e  RDW_MIX     = MIX_NEW,
  parameter bit        FORCE_ZERO  = 1'b1,
  localparam int BE_W = DATA_W / BYTE_W
) (
  input  logic              clk,
  input  logic              aclr,
  input  logic              a_ce_in,
  input  logic              a_ce_out,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [BE_W-1:0]   a_be,
  input  logic              a_we,
  input  logic              a_re,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_ce_in,
  input  logic              b_ce_out,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  input  logic [BE_W-1:0]   b_be,
  input  logic              b_we,
  input  logic              b_re,
  output logic [DATA_W-1:0] b_rdata
);
  localparam bit WR_A = port_writes(MODE, 1'b0);
  localparam bit WR_B = port_writes(MODE, 1'b1);
  localparam bit RD_A = port_reads(MODE, 1'b0);
  localparam bit RD_B = port_reads(MODE, 1'b1);

  generate
    if (!(BYTE_W == 5 || BYTE_W == 8 || BYTE_W == 9 || BYTE_W == 10) || (DATA_W % BYTE_W) != 0) begin : g_bad_byte
      $error("cfg_dpram: lane width must be 5, 8, 9 or 10 and divide the data width");
    end
    if (RDW_MIX == MIX_NEW && MODE != MODE_TRUE_DUAL) begin : g_bad_mix
      $error("cfg_dpram: cross-port new-data needs true dual-port mode");
    end
  endgenerate

  logic              a_wr, b_wr, a_hit, b_hit;
  logic [DATA_W-1:0] a_old, b_old;

  assign a_wr  = WR_A && (CE_IN_BYP_A || a_ce_in) && a_we;
  assign b_wr  = WR_B && (CE_IN_BYP_B || b_ce_in) && b_we;
  assign a_hit = b_wr && (b_addr == a_addr);
  assign b_hit = a_wr && (a_addr == b_addr);

  dpram_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BE_W(BE_W)) u_store (
    .clk(clk),
    .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_be(a_be),
    .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_be(b_be),
    .a_old(a_old), .b_old(b_old)
  );

  dpram_rd_port #(
    .DATA_W(DATA_W), .BE_W(BE_W), .CAN_READ(RD_A), .OUT_REG(OUT_REG_A),
    .ACLR_OUT(ACLR_OUT_A), .ACLR_ADDR(ACLR_ADDR_A), .CE_IN_BYP(CE_IN_BYP_A),
    .CE_OUT_BYP(CE_OUT_BYP_A), .SAME(RDW_A), .MIX(RDW_MIX), .FZ(FORCE_ZERO)
  ) u_port_a (
    .clk(clk), .aclr(aclr), .ce_in(a_ce_in), .ce_out(a_ce_out), .re(a_re),
    .we(a_wr), .wdata(a_wdata), .be(a_be), .old_word(a_old),
    .x_hit(a_hit), .x_wdata(b_wdata), .x_be(b_be), .rdata(a_rdata)
  );

  dpram_rd_port #(
    .DATA_W(DATA_W), .BE_W(BE_W), .CAN_READ(RD_B), .OUT_REG(OUT_REG_B),
    .ACLR_OUT(ACLR_OUT_B), .ACLR_ADDR(1'b0), .CE_IN_BYP(CE_IN_BYP_B),
    .CE_OUT_BYP(CE_OUT_BYP_B), .SAME(RDW_B), .MIX(RDW_MIX), .FZ(FORCE_ZERO)
  ) u_port_b (
    .clk(clk), .aclr(aclr), .ce_in(b_ce_in), .ce_out(b_ce_out), .re(b_re),
    .we(b_wr), .wdata(b_wdata), .be(b_be), .old_word(b_old),
    .x_hit(b_hit), .x_wdata(a_wdata), .x_be(a_be), .rdata(b_rdata)
  );
endmodule

// File: tb/cfg_dpram_tb.sv
module cfg_dpram_tb;
  import cfg_dpram_pkg::*;

  logic        clk = 1'b0;
  logic        aclr = 1'b1;
  logic        a_ce_in = 1'b1, a_ce_out = 1'b1, a_we = 1'b0, a_re = 1'b0;
  logic [3:0]  a_addr = '0;
  logic [15:0] a_wdata = '0;
  logic [1:0]  a_be = '0;
  logic        b_ce_in = 1'b1, b_ce_out = 1'b1, b_we = 1'b0, b_re = 1'b0;
  logic [3:0]  b_addr = '0;
  logic [15:0] b_wdata = '0;
  logic [1:0]  b_be = '0;
  logic [15:0] a_rdata, b_rdata, rom_a_rdata, rom_b_rdata;

  int    errors = 0;
  int    checks = 0;
  bit    done = 1'b0;
  bit    chk_on = 1'b0;
  string cur_req = "R9";

  always #2 clk = ~clk;

  cfg_dpram u_dut (
    .clk(clk), .aclr(aclr),
    .a_ce_in(a_ce_in), .a_ce_out(a_ce_out), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_be(a_be), .a_we(a_we), .a_re(a_re), .a_rdata(a_rdata),
    .b_ce_in(b_ce_in), .b_ce_out(b_ce_out), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_be(b_be), .b_we(b_we), .b_re(b_re), .b_rdata(b_rdata)
  );

  cfg_dpram #(.MODE(MODE_ROM), .RDW_MIX(MIX_OLD)) u_rom (
    .clk(clk), .aclr(aclr),
    .a_ce_in(a_ce_in), .a_ce_out(a_ce_out), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_be(a_be), .a_we(a_we), .a_re(a_re), .a_rdata(rom_a_rdata),
    .b_ce_in(1'b0), .b_ce_out(1'b0), .b_addr(4'd0), .b_wdata(16'd0),
    .b_be(2'b00), .b_we(1'b0), .b_re(1'b0), .b_rdata(rom_b_rdata)
  );

  // ---------------- behavioural reference ----------------
  logic [15:0] mem_m [16];
  logic [15:0] rd_a = '0, rd_b = '0, o_b = '0;
  bit          v_a = 0, v_b = 0, vo_b = 0;

  initial for (int i = 0; i < 16; i++) mem_m[i] = '0;

  // same: 0 masked-new, 1 keep-old-lanes, 2 old; mix: 0 dc, 1 new, 2 old
  function automatic logic [15:0] rd_res(logic [15:0] old, bit sw, logic [15:0] swd,
      logic [1:0] sbe, int same, bit xh, logic [15:0] xwd, logic [1:0] xbe, int mix);
    logic [15:0] r;
    for (int l = 0; l < 2; l++) begin
      if (sw && sbe[l])       r[l*8 +: 8] = (same == 2) ? old[l*8 +: 8] : swd[l*8 +: 8];
      else if (sw && same == 0) r[l*8 +: 8] = 8'bx;
      else if (xh && xbe[l])  r[l*8 +: 8] = (mix == 1) ? xwd[l*8 +: 8] :
                                            (mix == 2) ? old[l*8 +: 8] : 8'bx;
      else                    r[l*8 +: 8] = old[l*8 +: 8];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    bit wa, wb;
    logic [15:0] ra, rb;
    wa = a_ce_in && a_we;
    wb = b_ce_in && b_we;
    ra = rd_res(mem_m[a_addr], wa, a_wdata, a_be, 1, wb && (b_addr == a_addr), b_wdata, b_be, 1);
    rb = rd_res(mem_m[b_addr], wb, b_wdata, b_be, 2, wa && (a_addr == b_addr), a_wdata, a_be, 1);
    if (aclr) begin
      rd_a = '0; v_a = 0; o_b = '0; vo_b = 0;
    end else begin
      if (a_ce_in) begin v_a = a_re; if (a_re) rd_a = ra; end
      if (b_ce_out) begin o_b = rd_b; vo_b = v_b; end
    end
    if (b_ce_in) begin v_b = b_re; if (b_re) rd_b = rb; end
    for (int l = 0; l < 2; l++) begin
      if (wb && b_be[l]) mem_m[b_addr][l*8 +: 8] = b_wdata[l*8 +: 8];
      if (wa && a_be[l]) mem_m[a_addr][l*8 +: 8] = a_wdata[l*8 +: 8];
    end
  end

  function automatic bit differs(logic [15:0] act, logic [15:0] exp);
    for (int i = 0; i < 16; i++)
      if (exp[i] !== 1'bx && act[i] !== exp[i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (differs(act, exp)) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      check(cur_req, "port A", a_rdata, v_a ? rd_a : 16'h0);
      check(cur_req, "port B", b_rdata, vo_b ? o_b : 16'h0);
      check("R10", "read-only port", rom_a_rdata, 16'h0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive(bit awe, bit are, logic [3:0] aad, logic [15:0] awd, logic [1:0] abe,
                       bit bwe, bit bre, logic [3:0] bad, logic [15:0] bwd, logic [1:0] bbe);
    @(negedge clk);
    a_we = awe; a_re = are; a_addr = aad; a_wdata = awd; a_be = abe;
    b_we = bwe; b_re = bre; b_addr = bad; b_wdata = bwd; b_be = bbe;
  endtask

  task automatic idle(int n);
    repeat (n) drive(0, 0, 4'd0, 16'h0, 2'b00, 0, 0, 4'd0, 16'h0, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_on = 1'b1;                     // R9: reset state checked while clear held
    @(negedge clk);
    aclr = 1'b0;

    cur_req = "R1";
    drive(1, 0, 4'd3, 16'hA1B2, 2'b11, 1, 0, 4'd5, 16'h1234, 2'b10);
    drive(1, 0, 4'd3, 16'h55CC, 2'b01, 0, 0, 4'd0, 16'h0, 2'b00);
    drive(0, 1, 4'd3, 16'h0, 2'b00, 0, 1, 4'd5, 16'h0, 2'b00);
    drive(1, 1, 4'd9, 16'h7777, 2'b11, 1, 1, 4'd9, 16'h9999, 2'b11); // A wins collision
    drive(0, 1, 4'd9, 16'h0, 2'b00, 0, 1, 4'd3, 16'h0, 2'b00);
    cur_req = "R2";
    drive(0, 1, 4'd5, 16'h0, 2'b00, 0, 1, 4'd9, 16'h0, 2'b00);
    drive(0, 1, 4'd0, 16'h0, 2'b00, 0, 1, 4'd5, 16'h0, 2'b00);
    idle(3);

    cur_req = "R3";
    drive(1, 1, 4'd3, 16'hEE11, 2'b01, 0, 0, 4'd0, 16'h0, 2'b00);
    drive(1, 1, 4'd3, 16'h4400, 2'b10, 0, 0, 4'd0, 16'h0, 2'b00);
    idle(2);
    cur_req = "R4";
    drive(0, 0, 4'd0, 16'h0, 2'b00, 1, 1, 4'd5, 16'hBEEF, 2'b11);
    drive(0, 0, 4'd0, 16'h0, 2'b00, 1, 1, 4'd5, 16'h0F0F, 2'b01);
    drive(0, 0, 4'd0, 16'h0, 2'b00, 0, 1, 4'd5, 16'h0, 2'b00);
    idle(3);
    cur_req = "R5";
    drive(1, 0, 4'd7, 16'hC3D4, 2'b10, 0, 1, 4'd7, 16'h0, 2'b00);
    drive(0, 1, 4'd12, 16'h0, 2'b00, 1, 0, 4'd12, 16'h6A6A, 2'b11);
    idle(3);

    cur_req = "R6";
    drive(0, 1, 4'd3, 16'h0, 2'b00, 0, 1, 4'd3, 16'h0, 2'b00);
    idle(4);

    cur_req = "R7";
    drive(0, 1, 4'd5, 16'h0, 2'b00, 0, 1, 4'd5, 16'h0, 2'b00);
    a_ce_in = 1'b0; b_ce_in = 1'b0;
    drive(1, 1, 4'd5, 16'hDEAD, 2'b11, 1, 1, 4'd3, 16'hFACE, 2'b11);
    drive(1, 0, 4'd5, 16'hDEAD, 2'b11, 1, 0, 4'd3, 16'hFACE, 2'b11);
    @(negedge clk); a_ce_in = 1'b1; b_ce_in = 1'b1;
    drive(0, 1, 4'd3, 16'h0, 2'b00, 0, 1, 4'd5, 16'h0, 2'b00);
    idle(3);

    cur_req = "R8";
    drive(0, 0, 4'd0, 16'h0, 2'b00, 0, 1, 4'd7, 16'h0, 2'b00);
    drive(0, 0, 4'd0, 16'h0, 2'b00, 0, 1, 4'd3, 16'h0, 2'b00);
    b_ce_out = 1'b0;
    drive(0, 0, 4'd0, 16'h0, 2'b00, 0, 1, 4'd9, 16'h0, 2'b00);
    idle(2);
    @(negedge clk); b_ce_out = 1'b1;
    idle(3);

    cur_req = "R9";
    drive(0, 1, 4'd7, 16'h0, 2'b00, 0, 1, 4'd7, 16'h0, 2'b00);
    idle(1);
    #0.5 aclr = 1'b1;
    #0.5 check("R9", "A cleared at once", a_rdata, 16'h0);
    check("R9", "B cleared at once", b_rdata, 16'h0);
    idle(2);
    @(negedge clk); aclr = 1'b0;
    idle(2);

    cur_req = "R1";                    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      logic [3:0] aa, ba;
      bit aw, bw;
      aa = 4'($urandom_range(0, 15));
      ba = 4'($urandom_range(0, 15));
      aw = 1'($urandom_range(0, 1));
      bw = 1'($urandom_range(0, 1));
      if (aw && bw && aa == ba) bw = 1'b0;
      drive(aw, 1'($urandom_range(0, 1)), aa, 16'($urandom), 2'($urandom_range(0, 3)),
            bw, 1'($urandom_range(0, 1)), ba, 16'($urandom), 2'($urandom_range(0, 3)));
      a_ce_in = ($urandom_range(0, 7) != 0);
      b_ce_in = ($urandom_range(0, 7) != 0);
      b_ce_out = ($urandom_range(0, 7) != 0);
    end
    a_ce_in = 1'b1; b_ce_in = 1'b1; b_ce_out = 1'b1;
    idle(4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog %s: actual=running expected=finished", cur_req);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule